// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a write-only configuration port driven over three wires: a serial clock, a serial data line and an active-low latch enable. A host lowers the latch enable to open a frame. It then shifts in one 32-bit word, most significant bit first. Raising the latch enable ends the frame. The two least significant bits of the finished word select one of four 32-bit configuration registers, and the whole word, address bits included, is stored there. The port has no read path, no acknowledge and no handshake.

All three serial lines pass through two-flop synchronisers into the system clock domain. The edges of the serial clock and of the latch enable are then detected there. A frame commits only when exactly 32 bits arrived between the falling and rising edge of the latch enable. Other frames are dropped. A low level on the power-down input returns all four registers to their fixed non-zero defaults. Writing register 2 with its power-down bit cleared does the same. The four registers are presented in parallel as registered outputs.

Top module: `cfg_serial_regbank`

## Requirements
- R1: After reset the registers hold their defaults. Register 0 is 0x0007F1FC: code 127 in bits 11:2 and code 127 in bits 23:12, each meaning divide by 128. Register 1 is 0x0000007D. Register 2 is 0xDB6DB4A2. Register 3 is 0x00000027.
- R2: Data is sampled on each rising serial clock edge, first bit received ending up as bit 31. A committed word goes to the register numbered by its bits 1:0, and no other register changes.
- R3: Nothing is written until the latch enable rises. After 32 bits with latch enable still low, all registers are unchanged.
- R4: A frame with a bit count other than 32 at the latch-enable rising edge is discarded and no register is updated.
- R5: In register 3, bits 7, 8, 10 and 31:12 always read zero, whatever was written.
- R6: While pwr_dn_n is low, all four registers hold their R1 defaults, and frames completed during that time have no effect.
- R7: A committed word addressed to register 2 with bit 28 equal to 0 restores all four registers to their R1 defaults and is not stored.
- R8: Serial clock edges while latch enable is high shift nothing. A following well-formed 32-bit frame commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le_n | input | 1 | Latch enable, low during a frame, rising edge commits |
| pwr_dn_n | input | 1 | Active-low power-down, restores defaults |
| cfg0 | output | 32 | Configuration register 0 |
| cfg1 | output | 32 | Configuration register 1 |
| cfg2 | output | 32 | Configuration register 2 |
| cfg3 | output | 32 | Configuration register 3 |

## Verification
The hardest situation to reach is a frame of the wrong length at the latch-enable rising edge. A full 32-bit word must not commit early, and 31- or 33-bit frames must leave no trace. The stimulus mixes random words with random lengths of 31, 32 and 33 bits. It also includes a directed frame that pauses after the 32nd bit, so the registers can be checked before the latch enable rises. Random writes to register 2 often clear bit 28. This exercises the self-clearing path. Power-down is raised during a frame to confirm that the frame has no effect.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = 2;
  localparam int PD_BIT   = 28;
  localparam int PD_REG   = 2;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t DEF_R0 = word_t'((127 << 12) | (127 << 2) | 0);
  localparam word_t DEF_R1 = 32'h0000_007D;
  localparam word_t DEF_R2 = 32'hDB6D_B4A2;
  localparam word_t DEF_R3 = 32'h0000_0027;

  localparam word_t KEEP_ALL = '1;
  localparam word_t KEEP_R3  = 32'h0000_0A7F;

  function automatic word_t def_of(input int idx);
    case (idx)
      0:       return DEF_R0;
      1:       return DEF_R1;
      2:       return DEF_R2;
      default: return DEF_R3;
    endcase
  endfunction

  function automatic word_t keep_of(input int idx);
    return (idx == 3) ? KEEP_R3 : KEEP_ALL;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              le_n,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              sclk_q, le_q;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      le_q    <= 1'b1;
      cnt     <= '0;
      shreg   <= '0;
      wr_en   <= 1'b0;
      wr_word <= '0;
    end else begin
      sclk_q <= sclk;
      le_q   <= le_n;
      wr_en  <= 1'b0;
      if (le_q && !le_n) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (!le_n && sclk && !sclk_q) begin
        shreg <= {shreg[WORD_W-2:0], sdat};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (!le_q && le_n) begin
        wr_en   <= (cnt == CNT_W'(WORD_W));
        wr_word <= shreg;
        cnt     <= '0;
      end
    end
  end

  // R4: the bit counter saturates and never runs past its ceiling
  assert_count_sat_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CNT_MAX));
  // R3: a write strobe only follows a latch-enable rise and lasts one cycle
  assert_commit_on_le_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (le_q && $past(le_q) == 1'b0));
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pwr_dn_n,
  input  logic  wr_en,
  input  word_t wr_word,
  output word_t regs [NUM_REGS]
);
  logic pd_write;
  assign pd_write = wr_en && (wr_word[ADDR_W-1:0] == ADDR_W'(PD_REG)) && !wr_word[PD_BIT];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst || !pwr_dn_n || pd_write)
          regs[i] <= def_of(i);
        else if (wr_en && wr_word[ADDR_W-1:0] == ADDR_W'(i))
          regs[i] <= wr_word & keep_of(i);
      end
    end
  endgenerate

  // R5: reserved bits of register 3 stay zero
  assert_resv_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (regs[3] & ~KEEP_R3) == '0);
  // R6: power-down forces defaults on the next cycle
  assert_pd_defaults_R6: assert property (@(posedge clk) disable iff (rst)
    !pwr_dn_n |=> (regs[0] == DEF_R0 && regs[2] == DEF_R2));
  // R2: a write to another address leaves register 1 alone
  assert_addr_select_R2: assert property (@(posedge clk) disable iff (rst)
    (pwr_dn_n && !(wr_en && wr_word[1:0] == 2'd1) && !pd_write) |=> $stable(regs[1]));
endmodule

// File: rtl/cfg_serial_regbank.sv
module cfg_serial_regbank
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le_n,
  input  logic              pwr_dn_n,
  output logic [WORD_W-1:0] cfg0,
  output logic [WORD_W-1:0] cfg1,
  output logic [WORD_W-1:0] cfg2,
  output logic [WORD_W-1:0] cfg3
);
  logic [2:0] lines_s;
  logic       wr_en;
  word_t      wr_word;
  word_t      regs [NUM_REGS];

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_le_n, ser_data, ser_clk}),
    .q   (lines_s)
  );

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk    (lines_s[0]),
    .sdat    (lines_s[1]),
    .le_n    (lines_s[2]),
    .wr_en   (wr_en),
    .wr_word (wr_word)
  );

  cfg_regfile u_rf (
    .clk      (clk),
    .rst      (rst),
    .pwr_dn_n (pwr_dn_n),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .regs     (regs)
  );

  assign cfg0 = regs[0];
  assign cfg1 = regs[1];
  assign cfg2 = regs[2];
  assign cfg3 = regs[3];
endmodule

// File: tb/cfg_serial_regbank_bench.sv
module cfg_serial_regbank_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le_n = 1'b1, pwr_dn_n = 1'b1;
  logic [31:0] cfg0, cfg1, cfg2, cfg3;
  logic [31:0] expv [4];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_serial_regbank u_cfg_serial_regbank (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le_n(ser_le_n), .pwr_dn_n(pwr_dn_n),
    .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      0: return 32'h0007_F1FC;
      1: return 32'h0000_007D;
      2: return 32'hDB6D_B4A2;
      default: return 32'h0000_0027;
    endcase
  endfunction

  function automatic logic [31:0] keep(input int i);
    return (i == 3) ? 32'h0000_0A7F : 32'hFFFF_FFFF;
  endfunction

  task automatic load_defaults();
    for (int i = 0; i < 4; i++) expv[i] = dflt(i);
  endtask

  task automatic model(input logic [31:0] w, input int nbits);
    if (nbits != 32 || !pwr_dn_n) return;
    if (w[1:0] == 2'd2 && !w[28]) load_defaults();
    else expv[w[1:0]] = w & keep(w[1:0]);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req);
    logic [31:0] act [4];
    act[0] = cfg0; act[1] = cfg1; act[2] = cfg2; act[3] = cfg3;
    for (int i = 0; i < 4; i++) begin
      n_vec++;
      if (act[i] !== expv[i]) begin
        n_bad++;
        $display("FAIL %s reg%0d actual %h expected %h", req, i, act[i], expv[i]);
      end
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int nbits);
    for (int j = nbits - 1; j >= 0; j--) begin
      ser_data = (j < 32) ? w[j] : 1'b0;
      ticks(4); ser_clk = 1'b1;
      ticks(4); ser_clk = 1'b0;
    end
  endtask

  task automatic send(input logic [31:0] w, input int nbits);
    ser_le_n = 1'b0; ticks(4);
    shift_bits(w, nbits);
    ticks(4); ser_le_n = 1'b1; ticks(10);
  endtask

  initial begin
    ticks(200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FF_EE11));
    load_defaults();
    ticks(4); rst = 1'b0; ticks(4);
    check("R1 reset defaults");

    send(32'h1234_5679, 32); model(32'h1234_5679, 32);
    check("R2 write reg1 msb first");
    send(32'hA5A5_5A58, 32); model(32'hA5A5_5A58, 32);
    check("R2 write reg0 others unchanged");

    ser_le_n = 1'b0; ticks(4);
    shift_bits(32'h0F0F_F0F0, 32); ticks(12);
    check("R3 no commit before latch rise");
    ser_le_n = 1'b1; ticks(10); model(32'h0F0F_F0F0, 32);
    check("R3 commit on latch rise");

    send(32'h8765_4321, 31); check("R4 31-bit frame dropped");
    send(32'h8765_4321, 33); check("R4 33-bit frame dropped");

    send(32'hFFFF_FFFF, 32); model(32'hFFFF_FFFF, 32);
    check("R5 reserved reg3 bits zero");

    for (int k = 0; k < 6; k++) begin ser_clk = 1'b1; ticks(4); ser_clk = 1'b0; ticks(4); end
    check("R8 clocks with latch high ignored");
    send(32'h3C3C_3C3D, 32); model(32'h3C3C_3C3D, 32);
    check("R8 frame after idle clocks");

    send(32'h1000_0006, 32); model(32'h1000_0006, 32);
    check("R2 reg2 write with bit28 set stored");
    send(32'h2222_2222 & ~32'h1000_0000, 32); model(32'h2222_2222 & ~32'h1000_0000, 32);
    check("R7 reg2 bit28 clear restores defaults");

    send(32'hDEAD_BEEF, 32); model(32'hDEAD_BEEF, 32);
    pwr_dn_n = 1'b0; ticks(3); load_defaults();
    check("R6 power-down restores defaults");
    send(32'h5555_AAA9, 32);
    check("R6 frame ignored during power-down");
    pwr_dn_n = 1'b1; ticks(3);
    check("R6 defaults held after release");

    for (int k = 0; k < 50; k++) begin
      logic [31:0] w;
      int r, nb;
      w = $urandom();
      r = $urandom_range(0, 9);
      nb = (r == 0) ? 31 : (r == 1) ? 33 : 32;
      send(w, nb); model(w, nb);
      check(nb == 32 ? "R2 random frame" : "R4 random bad length");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule